// File: doc/BRIEF.md
# Multi-standard video sync generator

This block derives the complete line and field timing of an analog television raster from a single clock and a pixel-rate clock enable. A 3-bit selector picks one of five TV timing families. A line-mode input chooses between the standard frame length (625 or 525 lines, interlaced) and a reduced length one line shorter (624 or 524 lines). Reducing the frame by one line removes the half-line offset between fields, so the picture becomes progressive.

From a horizontal position counter and a line counter, the block decodes composite sync, composite blanking, a burst key, a clamp pulse, horizontal and vertical drive, and a white measurement pulse. The burst key becomes a chroma blanking signal for the SECAM family. The white measurement output is a tri-state pin. A line-identification flip-flop toggles once per line, and a qualified pulse on the set-identification input inverts it. This lets a system fix the phase-alternation field sequence. A frame reset input holds the raster at its first position for as long as it is asserted.

All horizontal positions come from a per-standard constant table. The table is written at a 13.5 MHz enable rate and divided by 2^SHIFT, so one netlist can serve slower enable rates or short simulations.

Top module: `vsync_gen`

## Requirements
- R1: `stdSel` codes 2 (PAL M) and 4 (NTSC) select the 525-line family, with a half-line of 429>>SHIFT enable counts, a blanking end at 136>>SHIFT and 6 equalizing half-lines. Every other code selects the 625-line family (0 PAL B/G, 1 PAL N, 3 SECAM; 5 to 7 behave as 0), with a half-line of 432>>SHIFT, a blanking end at 144>>SHIFT and 5 equalizing half-lines. In both families a line is two half-lines long.
- R2: On normal lines, all positions are counted from the line start (position 0), in enable counts. `cSync` is high for the first 64>>SHIFT counts. `hDrive` is high for the first 128>>SHIFT. `burstKey` is high from 72>>SHIFT up to, but not including, 112>>SHIFT. `clampPulse` is high from 112>>SHIFT up to the blanking end.
- R3: `cBlank` is high before the blanking end, during the last 16>>SHIFT counts of each line, and on whole half-lines of the vertical blanking zone. That zone covers field half-lines below 50 (625 family) or 40 (525 family), plus the trailing equalizing half-lines.
- R4: Field half-lines are numbered from 0 at each field start. Half-lines below the equalizing count carry broad pulses: `cSync` is high from each half-line start for (half-line length minus 64>>SHIFT) counts. The next equalizing-count half-lines, and the last equalizing-count half-lines of the field, carry equalizing pulses of 32>>SHIFT counts.
- R5: `vDrive` is high on field half-lines below three times the equalizing count.
- R6: In the standard line mode, each field has as many half-lines as the frame has lines. The second field therefore begins in the middle of line 312 (625) or line 262 (525).
- R7: With `shortMode` = 1, the frame has 624 or 524 lines. Both fields then start on a line boundary, and the line counter wraps one line earlier.
- R8: With `stdSel` = 3 (SECAM), `burstKey` carries the same waveform as `cBlank`.
- R9: `wmpOut` drives 1 on field half-line 54 (625) or 44 (525) outside horizontal blanking. At all other times it is high impedance.
- R10: `lineId` toggles at every line end and is 0 while frame reset is held.
- R11: `setId` is synchronized by two flops. A high pulse inverts `lineId` exactly once when it lasts at least SI_MIN clocks, and not at all when it is shorter.
- R12: After `rstN` is released, and while the two-flop-synchronized `frameRst` is high, the raster sits at line 0, position 0, with `lineId` = 0.
- R13: The counters advance only on clocks where `pixEn` is 1. With `pixEn` = 0, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rstN | input | 1 | asynchronous active-low reset |
| pixEn | input | 1 | pixel-rate clock enable |
| stdSel | input | 3 | TV timing family select |
| shortMode | input | 1 | 1 selects 624/524-line frames |
| frameRst | input | 1 | asynchronous frame reset, level held |
| setId | input | 1 | asynchronous identification inversion request |
| cSync | output | 1 | composite sync, active high |
| cBlank | output | 1 | composite blanking, active high |
| burstKey | output | 1 | burst key, or chroma blanking for SECAM |
| clampPulse | output | 1 | back-porch clamp pulse |
| hDrive | output | 1 | horizontal drive |
| vDrive | output | 1 | vertical drive |
| wmpOut | output | 1 | white measurement pulse, tri-state |
| lineId | output | 1 | half-line-rate identification |

## Verification
The bench builds the block with SHIFT = 4 and SI_MIN = 5. At SHIFT = 4 a 625-line frame takes about 34 thousand clocks, so the bench can reach the second-field boundary, the trailing equalizing zone and the frame wrap in reduced line mode with the divided horizontal constants. With SI_MIN = 5, a 4-clock and a 5-clock identification pulse sit on either side of the qualification limit. A long pulse shows that one inversion happens per pulse.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int TW = 16;
  localparam int LW = 10;
  localparam int HW = LW + 1;

  typedef struct packed {
    logic [TW-1:0] half;
    logic [TW-1:0] sync;
    logic [TW-1:0] eqW;
    logic [TW-1:0] burstOn;
    logic [TW-1:0] burstOff;
    logic [TW-1:0] blankEnd;
    logic [TW-1:0] porch;
    logic [TW-1:0] hdW;
    logic [LW-1:0] lines;
    logic [HW-1:0] eqHalf;
    logic [HW-1:0] vblHalf;
    logic [HW-1:0] vdHalf;
    logic [HW-1:0] wmpHalf;
    logic          secam;
  } timingT;

  typedef struct packed {
    logic hold;
    logic advance;
    logic idFlip;
  } strobeT;

  function automatic logic [TW-1:0] scaled(int base, int shift);
    return TW'(base >> shift);
  endfunction

  // Horizontal constants are written for a 13.5 MHz enable and divided by 2^shift.
  function automatic timingT stdTiming(logic [2:0] sel, logic shortMode, int shift);
    timingT t;
    logic is525;
    is525      = (sel == 3'd2) || (sel == 3'd4);
    t.half     = scaled(is525 ? 429 : 432, shift);
    t.sync     = scaled(64, shift);
    t.eqW      = scaled(32, shift);
    t.burstOn  = scaled(72, shift);
    t.burstOff = scaled(112, shift);
    t.blankEnd = scaled(is525 ? 136 : 144, shift);
    t.porch    = scaled(16, shift);
    t.hdW      = scaled(128, shift);
    t.lines    = LW'(is525 ? 525 : 625) - LW'(shortMode);
    t.eqHalf   = HW'(is525 ? 6 : 5);
    t.vblHalf  = HW'(is525 ? 40 : 50);
    t.vdHalf   = HW'(is525 ? 18 : 15);
    t.wmpHalf  = HW'(is525 ? 44 : 54);
    t.secam    = (sel == 3'd3);
    return t;
  endfunction
endpackage

// File: rtl/vsg_ctrl.sv
module vsg_ctrl
  import vsg_pkg::*;
#(
  parameter int SI_MIN = 22
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pixEn,
  input  logic   frameRst,
  input  logic   setId,
  output strobeT st
);
  localparam int CW = $clog2(SI_MIN + 1);

  logic [1:0]    frSync;
  logic [1:0]    siSync;
  logic [CW-1:0] siCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frSync <= '0;
      siSync <= '0;
      siCnt  <= '0;
    end else begin
      frSync <= {frSync[0], frameRst};
      siSync <= {siSync[0], setId};
      if (!siSync[1])
        siCnt <= '0;
      else if (siCnt != CW'(SI_MIN))
        siCnt <= siCnt + 1'b1;
    end
  end

  assign st.hold    = frSync[1];
  assign st.advance = pixEn;
  assign st.idFlip  = siSync[1] && (siCnt == CW'(SI_MIN - 1));

  AST_SI_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    st.idFlip |=> !st.idFlip); // R11
  AST_HOLD_SYNCED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.hold) |-> $past(frSync[0])); // R12
endmodule

// File: rtl/vsg_datapath.sv
module vsg_datapath
  import vsg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  timingT tim,
  input  strobeT st,
  output logic   cSync,
  output logic   cBlank,
  output logic   burstKey,
  output logic   clampPulse,
  output logic   hDrive,
  output logic   vDrive,
  output logic   wmpAct,
  output logic   lineId
);
  logic [TW-1:0] hPos;
  logic [TW-1:0] lineLen;
  logic [TW-1:0] hInHalf;
  logic [LW-1:0] lineCnt;
  logic [HW-1:0] hIdx;
  logic [HW-1:0] fIdx;
  logic [HW-1:0] fieldLen;
  logic lineEnd, frameEnd, secondHalf;
  logic inBroad, inEq, vZone, hBlank;

  assign lineLen  = tim.half << 1;
  assign lineEnd  = hPos >= lineLen - 1'b1;
  assign frameEnd = lineCnt >= tim.lines - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos    <= '0;
      lineCnt <= '0;
      lineId  <= 1'b0;
    end else if (st.hold) begin
      hPos    <= '0;
      lineCnt <= '0;
      lineId  <= 1'b0;
    end else begin
      if (st.advance) begin
        if (lineEnd) begin
          hPos    <= '0;
          lineCnt <= frameEnd ? '0 : lineCnt + 1'b1;
        end else begin
          hPos <= hPos + 1'b1;
        end
      end
      lineId <= lineId ^ (st.advance && lineEnd) ^ st.idFlip;
    end
  end

  // Half-line index inside the frame, folded into the current field.
  assign secondHalf = hPos >= tim.half;
  assign hInHalf    = secondHalf ? hPos - tim.half : hPos;
  assign hIdx       = {lineCnt, secondHalf};
  assign fieldLen   = HW'(tim.lines);
  assign fIdx       = (hIdx < fieldLen) ? hIdx : hIdx - fieldLen;

  assign inBroad = fIdx < tim.eqHalf;
  assign inEq    = !inBroad && ((fIdx < (tim.eqHalf << 1)) || (fIdx >= fieldLen - tim.eqHalf));
  assign vZone   = (fIdx < tim.vblHalf) || (fIdx >= fieldLen - tim.eqHalf);
  assign hBlank  = (hPos < tim.blankEnd) || (hPos >= lineLen - tim.porch);

  always_comb begin
    if (inBroad)   cSync = hInHalf < (tim.half - tim.sync);
    else if (inEq) cSync = hInHalf < tim.eqW;
    else           cSync = hPos < tim.sync;
  end

  assign cBlank     = vZone || hBlank;
  assign burstKey   = tim.secam ? cBlank
                                : (!vZone && (hPos >= tim.burstOn) && (hPos < tim.burstOff));
  assign clampPulse = (hPos >= tim.burstOff) && (hPos < tim.blankEnd);
  assign hDrive     = hPos < tim.hdW;
  assign vDrive     = fIdx < tim.vdHalf;
  assign wmpAct     = (fIdx == tim.wmpHalf) && !hBlank;

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    st.hold |=> (hPos == '0) && (lineCnt == '0) && !lineId); // R12
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!st.hold && !st.advance && !st.idFlip) |=> $stable(hPos) && $stable(lineCnt) && $stable(lineId)); // R13
  AST_ID_PER_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (!st.hold && st.advance && lineEnd && !st.idFlip) |=> (lineId != $past(lineId))); // R10
  AST_CLAMP_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    clampPulse |-> cBlank); // R2
  AST_HD_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    hDrive |-> cBlank); // R3
endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
  import vsg_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int SI_MIN = 22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixEn,
  input  logic [2:0] stdSel,
  input  logic       shortMode,
  input  logic       frameRst,
  input  logic       setId,
  output logic       cSync,
  output logic       cBlank,
  output logic       burstKey,
  output logic       clampPulse,
  output logic       hDrive,
  output logic       vDrive,
  output wire        wmpOut,
  output logic       lineId
);
  timingT tim;
  strobeT st;
  logic   wmpAct;

  always_comb tim = stdTiming(stdSel, shortMode, SHIFT);

  vsg_ctrl #(.SI_MIN(SI_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .frameRst(frameRst), .setId(setId), .st(st)
  );

  vsg_datapath u_dp (
    .clk(clk), .rstN(rstN), .tim(tim), .st(st),
    .cSync(cSync), .cBlank(cBlank), .burstKey(burstKey), .clampPulse(clampPulse),
    .hDrive(hDrive), .vDrive(vDrive), .wmpAct(wmpAct), .lineId(lineId)
  );

  assign wmpOut = wmpAct ? 1'b1 : 1'bz;
endmodule

// File: tb/vsync_gen_tb.sv
module vsync_gen_tb;
  localparam int SHIFT  = 4;
  localparam int SI_MIN = 5;
  localparam int NVEC   = 19;
  localparam int WDOG   = 190000;

  logic clk = 1'b0, rstN = 1'b0, pixEn = 1'b0, shortMode = 1'b0, frameRst = 1'b0, setId = 1'b0;
  logic [2:0] stdSel = 3'd0;
  logic cSync, cBlank, burstKey, clampPulse, hDrive, vDrive, lineId;
  wire  wmpOut;
  int   checks = 0, errors = 0;

  vsync_gen #(.SHIFT(SHIFT), .SI_MIN(SI_MIN)) u_dut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .stdSel(stdSel), .shortMode(shortMode),
    .frameRst(frameRst), .setId(setId), .cSync(cSync), .cBlank(cBlank), .burstKey(burstKey),
    .clampPulse(clampPulse), .hDrive(hDrive), .vDrive(vDrive), .wmpOut(wmpOut), .lineId(lineId)
  );

  always #4 clk = ~clk;

  // {std[2:0], short, line[9:0], hPos[7:0], expect{cs,cb,bk,cl,hd,vd,wmp}}
  localparam logic [28:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 10'd30,  8'd0,  7'b1100100},  // 0  R2 sync and drive at line start
    {3'd0, 1'b0, 10'd30,  8'd5,  7'b0110100},  // 1  R2 burst window
    {3'd0, 1'b0, 10'd30,  8'd8,  7'b0101000},  // 2  R2 clamp window
    {3'd0, 1'b0, 10'd30,  8'd20, 7'b0000000},  // 3  R3 active video
    {3'd0, 1'b0, 10'd30,  8'd53, 7'b0100000},  // 4  R3 front porch
    {3'd0, 1'b0, 10'd1,   8'd10, 7'b1100010},  // 5  R4 broad pulse
    {3'd0, 1'b0, 10'd3,   8'd3,  7'b0100110},  // 6  R4 equalizing, R5 vDrive
    {3'd0, 1'b0, 10'd27,  8'd20, 7'b0000001},  // 7  R9 white pulse driven
    {3'd0, 1'b0, 10'd27,  8'd30, 7'b0000000},  // 8  R9 white pulse released
    {3'd0, 1'b0, 10'd312, 8'd27, 7'b1100010},  // 9  R6 field 2 starts mid-line
    {3'd0, 1'b0, 10'd312, 8'd10, 7'b0100000},  // 10 R6 trailing equalizing
    {3'd0, 1'b1, 10'd312, 8'd10, 7'b1100010},  // 11 R7 reduced field on line boundary
    {3'd4, 1'b0, 10'd30,  8'd8,  7'b0000000},  // 12 R1 525 blanking end
    {3'd4, 1'b0, 10'd2,   8'd28, 7'b1100010},  // 13 R1 525 broad at second half
    {3'd4, 1'b0, 10'd262, 8'd27, 7'b1100010},  // 14 R6 525 field 2
    {3'd3, 1'b0, 10'd30,  8'd2,  7'b1110100},  // 15 R8 chroma blanking
    {3'd3, 1'b0, 10'd30,  8'd20, 7'b0000000},  // 16 R8 no blanking in video
    {3'd2, 1'b0, 10'd30,  8'd8,  7'b0000000},  // 17 R1 code 2 is 525 family
    {3'd4, 1'b1, 10'd524, 8'd10, 7'b1100010}   // 18 R7 524-line wrap
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1, 2:    return "R2";
      3, 4:       return "R3";
      5, 6:       return "R4";
      7, 8:       return "R9";
      9, 10, 14:  return "R6";
      11, 18:     return "R7";
      15, 16:     return "R8";
      default:    return "R1";
    endcase
  endfunction

  function automatic logic [6:0] sampled();
    logic w;
    w = (wmpOut === 1'b1) ? 1'b1 : ((wmpOut === 1'bz) ? 1'b0 : 1'bx);
    return {cSync, cBlank, burstKey, clampPulse, hDrive, vDrive, w};
  endfunction

  task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic frameStart(logic [2:0] s, logic sm);
    @(negedge clk) frameRst = 1'b1;
    repeat (4) @(negedge clk);
    stdSel = s;
    shortMode = sm;
    repeat (2) @(negedge clk);
    frameRst = 1'b0;
  endtask

  task automatic waitPos(int x);
    repeat (2 + x) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic siPulse(int w);
    setId = 1'b1;
    repeat (w) @(negedge clk);
    setId = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic runTests();
    // R12 reset state: line 0 position 0 of a 625 frame
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 reset outputs", sampled(), 7'b1100110);
    check("R12 reset lineId", {6'd0, lineId}, 7'd0);
    pixEn = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] v;
      int len;
      v = VEC[i];
      len = (v[28:26] == 3'd2 || v[28:26] == 3'd4) ? 52 : 54;  // R1 line lengths
      frameStart(v[28:26], v[25]);
      waitPos(int'(v[24:15]) * len + int'(v[14:7]));
      check(vecTag(i), sampled(), v[6:0]);
    end

    // R13 frozen counters
    frameStart(3'd0, 1'b0);
    waitPos(5);
    pixEn = 1'b0;
    repeat (20) @(negedge clk);
    check("R13 frozen at position 5", {cSync, hDrive, 5'd0}, 7'b1100000);
    pixEn = 1'b1;
    repeat (4) @(negedge clk);
    check("R13 resumed to position 9", {hDrive, 6'd0}, 7'd0);

    // R10 / R11 identification flip-flop
    frameStart(3'd0, 1'b0);
    waitPos(2);
    check("R10 lineId cleared", {6'd0, lineId}, 7'd0);
    siPulse(SI_MIN);
    check("R11 qualified pulse inverts", {6'd0, lineId}, 7'd1);
    siPulse(SI_MIN - 1);
    check("R11 short pulse ignored", {6'd0, lineId}, 7'd1);
    siPulse(20);
    check("R11 long pulse inverts once", {6'd0, lineId}, 7'd0);
    repeat (15) @(negedge clk);
    check("R10 toggle at line end", {6'd0, lineId}, 7'd1);

    // R12 frame reset held mid-frame
    frameRst = 1'b1;
    repeat (6) @(negedge clk);
    check("R12 held at frame start", {lineId, vDrive, hDrive, 4'd0}, 7'b0110000);
    frameRst = 1'b0;
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (WDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule